// File: doc/BRIEF.md
# DTMF Steering and Output Latch

This block sits behind a tone-pair detector. That detector reports that a valid row/column pair is present, together with the two indices. The block decides when the pair counts as a real key press and when the press is over. Two digital counters replace the usual resistor-capacitor timing network. Both count a slow time-unit strobe. One measures how long the pair must be seen before it is accepted. The other measures how long it must be gone before the press is released.

The block has three outputs. An early flag follows the raw detection. A four-bit key code is latched once the pair is accepted. A data-valid strobe rises the cycle after the latch and falls once the absence period has run out. The code stays on the data lines after release, until another press is accepted. An output-enable input floats the data lines. A power-down input silences both flags and abandons any timing in progress.

Top module: `dtmf_steer`

## Requirements
- R1: `earlySteer` equals `pairValid` from the previous clock edge, and is low instead when `powerDown` was high at that edge.
- R2: A pair is accepted only after it has been detected without break, with the same indices, for L ticks. L is `presentLimit` sampled when timing starts, and 0 counts as 1. The code is latched on the clock edge that samples the L-th tick.
- R3: `dataValid` rises exactly one clock after the code is latched, never on the same edge as a code change.
- R4: `dataValid` falls on the edge that samples the A-th tick of unbroken absence. A is `absentLimit` sampled when the absence starts, and 0 counts as 1. Any detection before then keeps `dataValid` high and restarts the absence measurement.
- R5: After release, the data lines keep the last accepted code until the next accepted press. After reset the code is 0000.
- R6: The code for row r (0 to 3, low to high frequency) and column c (0 to 3, low to high frequency) is, read row by row: r0 = 0001, 0010, 0011, 1101; r1 = 0100, 0101, 0110, 1110; r2 = 0111, 1000, 1001, 1111; r3 = 1011, 1010, 1100, 0000. Bit 3 is the MSB.
- R7: If the indices change while present timing runs, timing restarts from zero for the new pair, with `presentLimit` sampled again.
- R8: While `dataValid` is high, or while the absence is being timed, a different pair does not change the code. A new code needs a release and then a full present time.
- R9: With `outEnable` low, `digitDrive` is low and `digitOut` is high impedance, whatever `dataValid` is. With `outEnable` high, `digitOut` carries the latched code.
- R10: With `powerDown` high, `dataValid` and `earlySteer` are low from the next edge on, and any timing is dropped. A pair still present afterwards must requalify for the full present time.
- R11: Changing `presentLimit` or `absentLimit` while a timing phase runs does not change that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle time-unit strobe |
| pairValid | input | 1 | Detector reports a valid row/column pair |
| rowIdx | input | 2 | Row index, 0 = lowest frequency |
| colIdx | input | 2 | Column index, 0 = lowest frequency |
| presentLimit | input | LIMIT_W | Ticks needed before acceptance |
| absentLimit | input | LIMIT_W | Ticks of absence needed before release |
| outEnable | input | 1 | Data line drive enable |
| powerDown | input | 1 | Forces flags low and stops timing |
| earlySteer | output | 1 | Registered raw detection flag |
| dataValid | output | 1 | Accepted-key strobe |
| digitDrive | output | 1 | High while the data lines are driven |
| digitOut | output | 4 | Latched key code, high impedance when disabled |

## Verification
A stuck or wrongly sequenced control state shows up at `dataValid` within one tick period. It appears as an early rise, a missing fall, or a rise without a latch. A corrupted captured key or map entry shows up on `digitOut` on the edge after acceptance. A timer that loads the wrong limit, or that does not restart, moves the `dataValid` edges by whole tick periods. The bench therefore compares every output against a behavioural model on every cycle, so any of these faults is reported on the first cycle where it differs.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;
  localparam int ROW_W  = 2;
  localparam int COL_W  = 2;
  localparam int KEY_W  = ROW_W + COL_W;
  localparam int CODE_W = 4;
  localparam int LAST_COL = (1 << COL_W) - 1;
  localparam int LAST_ROW = (1 << ROW_W) - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRESENT,
    ST_LATCH,
    ST_VALID,
    ST_ABSENT
  } steerState_t;

  typedef struct packed {
    logic timerLoad;
    logic selAbsent;
    logic timerStep;
    logic keyCapture;
    logic codeLatch;
  } steerStrobe_t;

  // Keypad position to output code: the 3x3 digit block counts 1..9,
  // the last column encodes 13 + row (0 for the bottom row),
  // and the bottom row carries star, zero and pound.
  function automatic logic [CODE_W-1:0] keyToCode(input logic [ROW_W-1:0] row,
                                                  input logic [COL_W-1:0] col);
    int unsigned r;
    int unsigned c;
    int unsigned v;
    r = int'(row);
    c = int'(col);
    if (c == LAST_COL) begin
      v = (r == LAST_ROW) ? 0 : 13 + r;
    end else if (r == LAST_ROW) begin
      case (c)
        0:       v = 11;
        1:       v = 10;
        default: v = 12;
      endcase
    end else begin
      v = r * 3 + c + 1;
    end
    return CODE_W'(v);
  endfunction
endpackage

// File: rtl/dtmf_steer_ctrl.sv
module dtmf_steer_ctrl
  import dtmf_steer_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         pairValid,
  input  logic         powerDown,
  input  logic         keyMatch,
  input  logic         timerExpire,
  output steerStrobe_t strobe,
  output logic         dataValid
);
  steerState_t state, nextState;
  logic        dvNext;

  always_comb begin
    nextState = state;
    strobe    = '0;
    dvNext    = dataValid;
    if (powerDown) begin
      nextState = ST_IDLE;
      dvNext    = 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (pairValid) begin
            nextState         = ST_PRESENT;
            strobe.timerLoad  = 1'b1;
            strobe.keyCapture = 1'b1;
          end
        end
        ST_PRESENT: begin
          if (!pairValid) begin
            nextState = ST_IDLE;
          end else if (!keyMatch) begin
            strobe.timerLoad  = 1'b1;
            strobe.keyCapture = 1'b1;
          end else if (tick) begin
            if (timerExpire) begin
              strobe.codeLatch = 1'b1;
              nextState        = ST_LATCH;
            end else begin
              strobe.timerStep = 1'b1;
            end
          end
        end
        ST_LATCH: begin
          dvNext    = 1'b1;
          nextState = ST_VALID;
        end
        ST_VALID: begin
          if (!pairValid) begin
            nextState        = ST_ABSENT;
            strobe.timerLoad = 1'b1;
            strobe.selAbsent = 1'b1;
          end
        end
        ST_ABSENT: begin
          if (pairValid) begin
            nextState = ST_VALID;
          end else if (tick) begin
            if (timerExpire) begin
              dvNext    = 1'b0;
              nextState = ST_IDLE;
            end else begin
              strobe.timerStep = 1'b1;
            end
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      dataValid <= 1'b0;
    end else begin
      state     <= nextState;
      dataValid <= dvNext;
    end
  end
endmodule

// File: rtl/dtmf_steer_dp.sv
module dtmf_steer_dp
  import dtmf_steer_pkg::*;
#(
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pairValid,
  input  logic               powerDown,
  input  logic [ROW_W-1:0]   rowIdx,
  input  logic [COL_W-1:0]   colIdx,
  input  logic [LIMIT_W-1:0] presentLimit,
  input  logic [LIMIT_W-1:0] absentLimit,
  input  steerStrobe_t       strobe,
  output logic               keyMatch,
  output logic               timerExpire,
  output logic               earlySteer,
  output logic [CODE_W-1:0]  codeQ
);
  localparam int EXT_W = LIMIT_W + 1;

  logic [LIMIT_W-1:0] timerCnt;
  logic [LIMIT_W-1:0] timerLim;
  logic [KEY_W-1:0]   keyReg;
  logic [KEY_W-1:0]   keyNow;
  logic [EXT_W-1:0]   cntPlusOne;
  logic [EXT_W-1:0]   effLimit;

  assign keyNow     = {rowIdx, colIdx};
  assign keyMatch   = (keyReg == keyNow);
  assign cntPlusOne = {1'b0, timerCnt} + EXT_W'(1);
  assign effLimit   = (timerLim == '0) ? EXT_W'(1) : {1'b0, timerLim};
  assign timerExpire = (cntPlusOne >= effLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerCnt <= '0;
      timerLim <= '0;
    end else if (strobe.timerLoad) begin
      timerCnt <= '0;
      timerLim <= strobe.selAbsent ? absentLimit : presentLimit;
    end else if (strobe.timerStep) begin
      timerCnt <= cntPlusOne[LIMIT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyReg <= '0;
      codeQ  <= '0;
    end else begin
      if (strobe.keyCapture) keyReg <= keyNow;
      if (strobe.codeLatch)  codeQ  <= keyToCode(keyReg[KEY_W-1:COL_W], keyReg[COL_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) earlySteer <= 1'b0;
    else       earlySteer <= pairValid & ~powerDown;
  end
endmodule

// File: rtl/dtmf_steer.sv
module dtmf_steer
  import dtmf_steer_pkg::*;
#(
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               pairValid,
  input  logic [1:0]         rowIdx,
  input  logic [1:0]         colIdx,
  input  logic [LIMIT_W-1:0] presentLimit,
  input  logic [LIMIT_W-1:0] absentLimit,
  input  logic               outEnable,
  input  logic               powerDown,
  output logic               earlySteer,
  output logic               dataValid,
  output logic               digitDrive,
  output tri   [3:0]         digitOut
);
  steerStrobe_t      strobe;
  logic              keyMatch;
  logic              timerExpire;
  logic [CODE_W-1:0] codeQ;

  dtmf_steer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .pairValid  (pairValid),
    .powerDown  (powerDown),
    .keyMatch   (keyMatch),
    .timerExpire(timerExpire),
    .strobe     (strobe),
    .dataValid  (dataValid)
  );

  dtmf_steer_dp #(.LIMIT_W(LIMIT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .pairValid   (pairValid),
    .powerDown   (powerDown),
    .rowIdx      (rowIdx),
    .colIdx      (colIdx),
    .presentLimit(presentLimit),
    .absentLimit (absentLimit),
    .strobe      (strobe),
    .keyMatch    (keyMatch),
    .timerExpire (timerExpire),
    .earlySteer  (earlySteer),
    .codeQ       (codeQ)
  );

  assign digitDrive = outEnable;
  assign digitOut   = outEnable ? codeQ : 4'bzzzz;
endmodule

// File: rtl/dtmf_steer_chk.sv
module dtmf_steer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       pairValid,
  input logic       powerDown,
  input logic       earlySteer,
  input logic       dataValid,
  input logic [3:0] codeQ
);
  AST_EARLY_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    earlySteer |-> ($past(pairValid) && !$past(powerDown))); // R1

  AST_DV_RISE_CODE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |-> $stable(codeQ)); // R3

  AST_DV_FALL_AFTER_ABSENCE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataValid) |-> (!$past(pairValid) || $past(powerDown))); // R4

  AST_CODE_MOVES_ONLY_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(codeQ) |-> (!dataValid && !$past(dataValid))); // R8

  AST_POWERDOWN_SILENCES: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> (!dataValid && !earlySteer)); // R10
endmodule

bind dtmf_steer dtmf_steer_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pairValid (pairValid),
  .powerDown (powerDown),
  .earlySteer(earlySteer),
  .dataValid (dataValid),
  .codeQ     (codeQ)
);

// File: tb/tb_dtmf_steer.sv
module tb_dtmf_steer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       pairValid = 1'b0;
  logic [1:0] rowIdx = '0;
  logic [1:0] colIdx = '0;
  logic [7:0] presentLimit = 8'd2;
  logic [7:0] absentLimit = 8'd2;
  logic       outEnable = 1'b1;
  logic       powerDown = 1'b0;
  logic       tickOn = 1'b0;
  logic       earlySteer, dataValid, digitDrive;
  wire  [3:0] digitOut;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  dtmf_steer dut (
    .clk(clk), .rstN(rstN), .tick(tick), .pairValid(pairValid),
    .rowIdx(rowIdx), .colIdx(colIdx), .presentLimit(presentLimit),
    .absentLimit(absentLimit), .outEnable(outEnable), .powerDown(powerDown),
    .earlySteer(earlySteer), .dataValid(dataValid), .digitDrive(digitDrive),
    .digitOut(digitOut)
  );

  always #2 clk = ~clk;

  // tick every fourth cycle
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv <= (tdiv + 1) % 4;
    tick <= tickOn && (tdiv == 3);
  end

  function automatic int expCode(input int r, input int c);
    case (r * 4 + c)
      0: return 1;   1: return 2;   2: return 3;   3: return 13;
      4: return 4;   5: return 5;   6: return 6;   7: return 14;
      8: return 7;   9: return 8;  10: return 9;  11: return 15;
     12: return 11; 13: return 10; 14: return 12; 15: return 0;
      default: return 0;
    endcase
  endfunction

  // behavioural reference: phase 0 idle, 1 timing presence, 2 just latched,
  // 3 held, 4 timing absence
  int mPh = 0, mCnt = 0, mLim = 0, mKey = 0, mCode = 0;
  bit mDv = 0, mEs = 0;
  always @(posedge clk) begin
    int key;
    int lim;
    key = int'(rowIdx) * 4 + int'(colIdx);
    lim = (mLim < 1) ? 1 : mLim;
    if (!rstN) begin
      mPh <= 0; mCnt <= 0; mLim <= 0; mKey <= 0; mCode <= 0; mDv <= 0; mEs <= 0;
    end else begin
      mEs <= pairValid && !powerDown;
      if (powerDown) begin
        mPh <= 0; mDv <= 0;
      end else if (mPh == 0) begin
        if (pairValid) begin mPh <= 1; mCnt <= 0; mLim <= presentLimit; mKey <= key; end
      end else if (mPh == 1) begin
        if (!pairValid) mPh <= 0;
        else if (key != mKey) begin mCnt <= 0; mLim <= presentLimit; mKey <= key; end
        else if (tick) begin
          if (mCnt + 1 >= lim) begin mCode <= expCode(mKey / 4, mKey % 4); mPh <= 2; end
          else mCnt <= mCnt + 1;
        end
      end else if (mPh == 2) begin
        mDv <= 1; mPh <= 3;
      end else if (mPh == 3) begin
        if (!pairValid) begin mPh <= 4; mCnt <= 0; mLim <= absentLimit; end
      end else begin
        if (pairValid) mPh <= 3;
        else if (tick) begin
          if (mCnt + 1 >= lim) begin mDv <= 0; mPh <= 0; end
          else mCnt <= mCnt + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(earlySteer == mEs, "R1 earlySteer", int'(earlySteer), int'(mEs));
      check(dataValid == mDv, "R3/R4 dataValid", int'(dataValid), int'(mDv));
      check(digitDrive == outEnable, "R9 digitDrive", int'(digitDrive), int'(outEnable));
      if (digitDrive)
        check(int'(digitOut) == mCode, "R6 digitOut", int'(digitOut), mCode);
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input int r, input int c);
    rowIdx = 2'(r); colIdx = 2'(c); pairValid = 1'b1;
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    tickOn = 1'b1;
    waitCyc(1);
    // reset state (R5)
    check(dataValid == 0, "R5 reset dataValid", int'(dataValid), 0);
    check(int'(digitOut) == 0, "R5 reset code", int'(digitOut), 0);

    // every key (R2, R4, R5, R6)
    for (int k = 0; k < 16; k++) begin
      press(k / 4, k % 4);
      waitCyc(24);
      check(dataValid == 1, "R2 accepted", int'(dataValid), 1);
      check(int'(digitOut) == expCode(k / 4, k % 4), "R6 code map", int'(digitOut), expCode(k / 4, k % 4));
      pairValid = 1'b0;
      waitCyc(24);
      check(dataValid == 0, "R4 released", int'(dataValid), 0);
      check(int'(digitOut) == expCode(k / 4, k % 4), "R5 code kept", int'(digitOut), expCode(k / 4, k % 4));
    end

    // short tone is rejected (R2)
    presentLimit = 8'd5;
    press(0, 0);
    waitCyc(6);
    pairValid = 1'b0;
    waitCyc(30);
    check(dataValid == 0, "R2 short tone", int'(dataValid), 0);
    check(int'(digitOut) == 0, "R2 code unchanged", int'(digitOut), 0);

    // pair change during present timing restarts (R7)
    presentLimit = 8'd3;
    press(0, 0);
    waitCyc(6);
    press(2, 2);
    waitCyc(40);
    check(int'(digitOut) == 9, "R7 restarted pair", int'(digitOut), 9);

    // other pair while held gives no new code (R8)
    press(1, 1);
    waitCyc(40);
    check(int'(digitOut) == 9, "R8 held code", int'(digitOut), 9);
    // dropout shorter than absent time (R4)
    absentLimit = 8'd6;
    pairValid = 1'b0;
    waitCyc(6);
    pairValid = 1'b1;
    waitCyc(3);
    check(dataValid == 1, "R4 dropout ignored", int'(dataValid), 1);
    check(int'(digitOut) == 9, "R8 no relatch after dropout", int'(digitOut), 9);

    // output enable low (R9)
    outEnable = 1'b0;
    waitCyc(2);
    check(digitDrive == 0, "R9 floated", int'(digitDrive), 0);
    outEnable = 1'b1;

    // power-down while held, then requalify (R10)
    powerDown = 1'b1;
    waitCyc(2);
    check(dataValid == 0 && earlySteer == 0, "R10 silenced", int'(dataValid), 0);
    powerDown = 1'b0;
    waitCyc(2);
    check(dataValid == 0, "R10 requalify", int'(dataValid), 0);
    waitCyc(40);
    check(dataValid == 1, "R10 reaccepted", int'(dataValid), 1);
    pairValid = 1'b0;
    absentLimit = 8'd2;
    waitCyc(40);

    // limit sampled at phase start (R11)
    presentLimit = 8'd8;
    press(3, 0);
    waitCyc(8);
    presentLimit = 8'd1;
    waitCyc(12);
    check(dataValid == 0, "R11 limit held", int'(dataValid), 0);
    waitCyc(40);
    check(int'(digitOut) == 11, "R11 accepted later", int'(digitOut), 11);
    pairValid = 1'b0;

    // zero limit behaves as one tick (R2)
    waitCyc(40);
    presentLimit = 8'd0;
    press(0, 3);
    waitCyc(10);
    check(int'(digitOut) == 13, "R2 zero limit", int'(digitOut), 13);
    pairValid = 1'b0;
    waitCyc(30);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule